// File: doc/BRIEF.md
# Pin-Level Radio State Commander

This block gives a radio controller a way to change its main operating state from three pins of its serial port, without running a serial transaction. While the chip-select pin is high, the data-in pin and the serial clock pin are held at a two-bit code that names the wanted state. When chip select falls, the block takes that code. If the code names a state other than the current one, the block raises a one-cycle command strobe and moves its state register. If the code names the current state, nothing happens and the state is not restarted.

The block keeps track of the current state and drives it out. There are four states: SLEEP, IDLE, RX and TX. A command to enter SLEEP does not act when chip select falls. It is held until chip select goes high again and acts then. The mechanism works only while a configuration enable input is high. All three pins come from outside the clock domain, so they pass through a shared synchroniser before the edge logic sees them.

Top module: `pin_state_cmd`

## Requirements
- R1: After reset the current state is IDLE (2'b00) and no strobe is active.
- R2: The state code is {sdi, sclk} with 00 = IDLE, 01 = RX, 10 = TX and 11 = SLEEP. The code used is the last one sampled while chip select was high. On a falling edge of chip select, a code other than SLEEP that differs from the current state raises the strobe for that state for one cycle and makes it the current state.
- R3: When the code taken on a falling edge of chip select equals the current state, no strobe is raised and the state stays the same.
- R4: While chip select is low, changes on sdi and sclk issue no command and do not alter the code that was taken.
- R5: A SLEEP code that differs from the current state causes no action when chip select falls. The SLEEP strobe and the change to SLEEP (2'b11) happen on the next rising edge of chip select.
- R6: While the enable input is low, edges of chip select issue no commands. Dropping the enable while a SLEEP command is waiting cancels that command.
- R7: With the default two synchroniser stages, a strobe is high for exactly one cycle. For an immediate command it is visible after the third rising clock edge, counting the first edge that samples chip select low.
- R8: At most one strobe is active in any cycle. An active strobe always matches the current-state output in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Enables pin-level state commands |
| cs_n | input | 1 | Serial chip select pin, asynchronous |
| sdi | input | 1 | Serial data-in pin; high bit of the state code |
| sclk | input | 1 | Serial clock pin; low bit of the state code |
| stb_idle | output | 1 | One-cycle strobe: enter IDLE |
| stb_rx | output | 1 | One-cycle strobe: enter RX |
| stb_tx | output | 1 | One-cycle strobe: enter TX |
| stb_sleep | output | 1 | One-cycle strobe: enter SLEEP |
| cur_state | output | 2 | Current state, encoded as in R2 |

## Verification
The assertions assume that mode_en is driven synchronously to clk. They also assume that sdi and sclk do not change in the same cycle in which the synchronised chip select falls, so that the code taken is a clean level. The stimulus meets these assumptions. It sets the code and then holds it for several cycles before lowering chip select. It scrambles the two pins only after chip select is low, and it changes the enable only on the falling clock edge. The sleep-cancel case drops the enable while chip select is low and a SLEEP command is waiting. The repeated-code cases send the same code several times in a row and confirm that no strobe follows.

// File: rtl/pin_cmd_pkg.sv
package pin_cmd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_RX    = 2'b01,
        ST_TX    = 2'b10,
        ST_SLEEP = 2'b11
    } radio_st_e;

    localparam int unsigned NUM_STATES = 4;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned      WIDTH   = 3,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef logic [WIDTH-1:0] word_t;

    word_t chain_d [STAGES];
    word_t chain_q [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cmd_capture.sv
module cmd_capture #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic [CODE_W-1:0] code_s,
    output logic              fall_o,
    output logic              rise_o,
    output logic [CODE_W-1:0] code_o
);

    typedef struct packed {
        logic              cs_prev;
        logic [CODE_W-1:0] hold;
    } cap_t;

    cap_t r_q, r_d;

    always_comb begin
        r_d         = r_q;
        r_d.cs_prev = cs_s;
        // the code follows the pins only while chip select is high
        if (cs_s) begin
            r_d.hold = code_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cs_prev <= 1'b1;
            r_q.hold    <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign fall_o = r_q.cs_prev & ~cs_s;
    assign rise_o = ~r_q.cs_prev & cs_s;
    assign code_o = r_q.hold;

    // R4: the taken code is frozen while chip select stays low
    assert_code_frozen_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cs_s) && !cs_s) |-> $stable(code_o));

endmodule

// File: rtl/state_track.sv
module state_track
    import pin_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  cs_s,
    input  logic                  fall,
    input  logic                  rise,
    input  logic [1:0]            code,
    output logic [NUM_STATES-1:0] stb_o,
    output radio_st_e             state_o
);

    typedef struct packed {
        radio_st_e             state;
        logic                  pend;
        logic [NUM_STATES-1:0] stb;
    } trk_t;

    trk_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.stb = '0;
        if (!en) begin
            r_d.pend = 1'b0;
        end else if (fall) begin
            if (code != r_q.state) begin
                if (radio_st_e'(code) == ST_SLEEP) begin
                    r_d.pend = 1'b1;
                end else begin
                    r_d.state     = radio_st_e'(code);
                    r_d.stb[code] = 1'b1;
                end
            end
        end else if (rise && r_q.pend) begin
            r_d.pend          = 1'b0;
            r_d.state         = ST_SLEEP;
            r_d.stb[ST_SLEEP] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.pend  <= 1'b0;
            r_q.stb   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stb_o   = r_q.stb;
    assign state_o = r_q.state;

    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(stb_o));

    assert_strobe_matches_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o != '0) |-> stb_o[state_o]);

    assert_change_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != $past(state_o)) |-> (stb_o != '0));

    assert_strobe_is_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_o != '0) |-> (state_o != $past(state_o)));

    assert_sleep_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o[ST_SLEEP] |-> $past(cs_s));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> (stb_o == '0));

endmodule

// File: rtl/pin_state_cmd.sv
module pin_state_cmd
    import pin_cmd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_en,
    input  logic       cs_n,
    input  logic       sdi,
    input  logic       sclk,
    output logic       stb_idle,
    output logic       stb_rx,
    output logic       stb_tx,
    output logic       stb_sleep,
    output logic [1:0] cur_state
);

    localparam int unsigned CODE_W = $clog2(NUM_STATES);
    localparam int unsigned PIN_W  = CODE_W + 1;

    logic [PIN_W-1:0]      pins_s;
    logic                  fall, rise;
    logic [CODE_W-1:0]     code;
    logic [NUM_STATES-1:0] stb;
    radio_st_e             state;

    pin_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({1'b1, {CODE_W{1'b0}}})
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({cs_n, sdi, sclk}),
        .dout  (pins_s)
    );

    cmd_capture #(
        .CODE_W (CODE_W)
    ) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_s   (pins_s[PIN_W-1]),
        .code_s (pins_s[CODE_W-1:0]),
        .fall_o (fall),
        .rise_o (rise),
        .code_o (code)
    );

    state_track i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mode_en),
        .cs_s    (pins_s[PIN_W-1]),
        .fall    (fall),
        .rise    (rise),
        .code    (code),
        .stb_o   (stb),
        .state_o (state)
    );

    assign stb_idle  = stb[ST_IDLE];
    assign stb_rx    = stb[ST_RX];
    assign stb_tx    = stb[ST_TX];
    assign stb_sleep = stb[ST_SLEEP];
    assign cur_state = state;

    // R7: a strobe never lasts two cycles
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb != '0) |=> (stb == '0));

endmodule

// File: tb/test_pin_state_cmd.sv
`timescale 1ns/1ps
module test_pin_state_cmd;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic cs = 1'b1;
    logic si = 1'b0;
    logic sk = 1'b0;
    logic s_idle, s_rx, s_tx, s_sleep;
    logic [1:0] st;

    always #5 clk = ~clk;

    pin_state_cmd i_pin_state_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (en),
        .cs_n      (cs),
        .sdi       (si),
        .sclk      (sk),
        .stb_idle  (s_idle),
        .stb_rx    (s_rx),
        .stb_tx    (s_tx),
        .stb_sleep (s_sleep),
        .cur_state (st)
    );

    int checks = 0;
    int errors = 0;
    int cnt [4];

    // reference model state
    int m_state, m_pend, m_hold;
    int m_stb [4];
    int h_cs [3];
    int h_code [3];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural model, evaluated at each rising edge on pin values seen there
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_pend = 0; m_hold = 0;
            for (int i = 0; i < 4; i++) m_stb[i] = 0;
            for (int i = 0; i < 3; i++) begin h_cs[i] = 1; h_code[i] = 0; end
        end else begin
            bit fall_e, rise_e;
            fall_e = (h_cs[2] == 1) && (h_cs[1] == 0);
            rise_e = (h_cs[2] == 0) && (h_cs[1] == 1);
            for (int i = 0; i < 4; i++) m_stb[i] = 0;
            if (!en) m_pend = 0;
            else if (fall_e && m_hold != m_state) begin
                if (m_hold == 3) m_pend = 1;
                else begin m_state = m_hold; m_stb[m_hold] = 1; end
            end else if (rise_e && m_pend == 1) begin
                m_pend = 0; m_state = 3; m_stb[3] = 1;
            end
            if (h_cs[1] == 1) m_hold = h_code[1];
            h_cs[2] = h_cs[1]; h_code[2] = h_code[1];
            h_cs[1] = h_cs[0]; h_code[1] = h_code[0];
            h_cs[0] = cs;      h_code[0] = {si, sk};
        end
    end

    // per-cycle comparison and strobe counting
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 state vs model", st, m_state);
            chk("R7 strobes vs model", {s_sleep, s_tx, s_rx, s_idle},
                m_stb[3]*8 + m_stb[2]*4 + m_stb[1]*2 + m_stb[0]);
            chk("R8 at most one strobe", $countones({s_sleep, s_tx, s_rx, s_idle}) <= 1, 1);
            cnt[0] += s_idle; cnt[1] += s_rx; cnt[2] += s_tx; cnt[3] += s_sleep;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] code, input int low_n);
        @(negedge clk);
        cs = 1'b1; {si, sk} = code;
        cyc(4);
        cs = 1'b0;
        for (int i = 0; i < low_n; i++) begin
            @(negedge clk);
            {si, sk} = 2'(i + 1);
        end
        @(negedge clk);
        cs = 1'b1;
        cyc(5);
    endtask

    task automatic probe(input string tag, input int exp_st, input int c0, input int c1,
                         input int c2, input int c3);
        @(negedge clk); #1;
        chk({tag, " state"}, st, exp_st);
        chk({tag, " idle count"}, cnt[0], c0);
        chk({tag, " rx count"}, cnt[1], c1);
        chk({tag, " tx count"}, cnt[2], c2);
        chk({tag, " sleep count"}, cnt[3], c3);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        cyc(3);
        #1;
        chk("R1 reset state", st, 0);
        chk("R1 reset strobes", {s_sleep, s_tx, s_rx, s_idle}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;
        cyc(3);
        probe("R1 idle after release", 0, 0, 0, 0, 0);

        issue(2'b01, 3);  probe("R2 IDLE to RX", 1, 0, 1, 0, 0);
        issue(2'b01, 3);  probe("R3 repeat RX", 1, 0, 1, 0, 0);
        issue(2'b01, 6);  probe("R3 repeat RX again", 1, 0, 1, 0, 0);
        issue(2'b10, 4);  probe("R2 RX to TX", 2, 0, 1, 1, 0);
        issue(2'b00, 4);  probe("R2 TX to IDLE", 0, 1, 1, 1, 0);
        issue(2'b00, 2);  probe("R3 repeat IDLE", 0, 1, 1, 1, 0);

        // deferred sleep
        @(negedge clk); cs = 1'b1; {si, sk} = 2'b11;
        cyc(4); cs = 1'b0;
        cyc(8);
        probe("R5 sleep held while low", 0, 1, 1, 1, 0);
        cs = 1'b1;
        cyc(5);
        probe("R5 sleep on rise", 3, 1, 1, 1, 1);
        issue(2'b11, 3);  probe("R3 repeat SLEEP", 3, 1, 1, 1, 1);
        issue(2'b01, 3);  probe("R2 SLEEP to RX", 1, 1, 2, 1, 1);
        issue(2'b11, 3);  probe("R5 RX to SLEEP", 3, 1, 2, 1, 2);
        issue(2'b10, 3);  probe("R2 SLEEP to TX", 2, 1, 2, 2, 2);

        // long low period with scrambled pins
        issue(2'b01, 40); probe("R4 scrambled pins ignored", 1, 1, 3, 2, 2);

        // enable off
        en = 1'b0;
        issue(2'b10, 3);  probe("R6 disabled no command", 1, 1, 3, 2, 2);
        issue(2'b11, 3);  probe("R6 disabled no sleep", 1, 1, 3, 2, 2);
        en = 1'b1;
        cyc(4);
        probe("R6 no late action on re-enable", 1, 1, 3, 2, 2);

        // cancel pending sleep
        @(negedge clk); cs = 1'b1; {si, sk} = 2'b11;
        cyc(4); cs = 1'b0;
        cyc(5); en = 1'b0;
        cyc(2); cs = 1'b1;
        cyc(5); en = 1'b1;
        cyc(4);
        probe("R6 pending sleep cancelled", 1, 1, 3, 2, 2);

        // latency
        @(negedge clk); cs = 1'b1; {si, sk} = 2'b10;
        cyc(4);
        cs = 1'b0;
        @(negedge clk); #1; chk("R7 edge1 no strobe", s_tx, 0);
        @(negedge clk); #1; chk("R7 edge2 no strobe", s_tx, 0);
        @(negedge clk); #1; chk("R7 edge3 strobe", s_tx, 1);
        chk("R8 strobe matches state", st, 2);
        @(negedge clk); #1; chk("R7 edge4 strobe gone", s_tx, 0);
        cs = 1'b1;
        cyc(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule